// File: doc/BRIEF.md
# Dual-Input Proportional Fan PWM Generator

This block drives a fan switch with a fixed-rate pulse-width signal. Two digital control codes come in: a temperature code and a minimum-speed code. The larger of the two sets the duty cycle, so the minimum-speed code works as a floor under the thermal demand. The PWM period is built from a prescaler on the system clock and a slot counter. With the default parameters and a 50 MHz clock, this gives a rate of about 30 Hz. The chosen duty is captured once per period, at the period boundary, so a new setting never cuts into a period already running.

Several outputs serve neighbouring logic. A one-cycle strobe at every period boundary acts as the time base for fan supervision timers. A one-cycle pulse marks each rising edge of the drive signal, and the sense path uses it for blanking. An over-temperature flag follows the temperature code whenever that code demands full duty. The flag clears by itself, and the fan keeps running while it is set. A supervisor can override the computed drive in either direction. Forcing the output off wins over forcing it on.

Top module: `fan_pwm_gen`

## Requirements
- R1: While reset is asserted, and for two clock cycles after it is released, `pwm_out`, `period_strobe`, `rise_pulse` and `over_temp` are 0.
- R2: One PWM period lasts PRESC_DIV × FULL_SCALE clock cycles. `period_strobe` pulses for exactly one cycle once per period.
- R3: With no override, the drive is high for min(max(temp_code, floor_code), FULL_SCALE) × PRESC_DIV cycles of each period. The high time starts at the beginning of the period.
- R4: The duty is captured only at a period boundary. A code change in the middle of a period leaves that period's high time unchanged.
- R5: When both codes are 0, the output never goes high. A code at or above FULL_SCALE gives a high time that fills the whole period.
- R6: `over_temp` is 1 in the cycle after `temp_code` ≥ FULL_SCALE, and 0 in the cycle after `temp_code` < FULL_SCALE. `floor_code` has no effect on it.
- R7: `force_off` drives `pwm_out` to 0 from the next cycle, whatever the state of `force_on`. When `force_off` is low, `force_on` drives `pwm_out` to 1 from the next cycle.
- R8: `rise_pulse` is 1 for exactly the cycle in which `pwm_out` goes from 0 to 1, and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| temp_code | input | CODE_W | Temperature demand code |
| floor_code | input | CODE_W | Minimum-speed floor code |
| force_on | input | 1 | Supervisor override that holds the drive high |
| force_off | input | 1 | Shutdown override that holds the drive low; wins over force_on |
| pwm_out | output | 1 | Fan switch drive |
| period_strobe | output | 1 | One-cycle pulse at each period boundary |
| rise_pulse | output | 1 | One-cycle pulse on each rising edge of pwm_out |
| over_temp | output | 1 | Non-latching full-demand flag |

## Verification
A wrong prescaler or slot count shows up on `period_strobe` within one period as a wrong spacing. A wrong captured duty changes the number of high cycles in the next full period, and a capture taken mid-period changes the current one. The bench runs a behavioural model in step with the design and compares all four outputs on every cycle. An override or flag error therefore appears at the ports one cycle after the stimulus. Dedicated windows also count high cycles per period and the spacing between strobes, so the period-level behaviour is checked directly as well.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
  // Source chosen for the drive register in a given cycle.
  typedef enum logic [1:0] {
    DRV_DUTY = 2'd0,
    DRV_HIGH = 2'd1,
    DRV_LOW  = 2'd2
  } drv_src_t;
endpackage

// File: rtl/fan_pwm_prescaler.sv
module fan_pwm_prescaler #(
  parameter int PRESC_DIV = 8333
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = $clog2(PRESC_DIV + 1);
  localparam logic [PW-1:0] LAST = PW'(PRESC_DIV - 1);

  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R2
endmodule

// File: rtl/fan_pwm_slot_ctr.sv
module fan_pwm_slot_ctr #(
  parameter int FULL_SCALE = 200,
  localparam int SW = $clog2(FULL_SCALE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [SW-1:0] slot,
  output logic          wrap
);
  localparam logic [SW-1:0] LAST = SW'(FULL_SCALE - 1);

  logic [SW-1:0] slot_q, slot_d;

  always_comb begin
    wrap   = tick && (slot_q == LAST);
    slot_d = slot_q;
    if (tick) slot_d = wrap ? '0 : slot_q + SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  assign slot = slot_q;

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= LAST); // R2
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(slot_q)); // R2
endmodule

// File: rtl/fan_pwm_duty_sel.sv
module fan_pwm_duty_sel #(
  parameter int CODE_W     = 8,
  parameter int FULL_SCALE = 200,
  localparam int SW = $clog2(FULL_SCALE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap,
  input  logic [CODE_W-1:0] temp_code,
  input  logic [CODE_W-1:0] floor_code,
  output logic [SW-1:0]     duty,
  output logic              over_temp
);
  localparam logic [CODE_W-1:0] FS_CODE = CODE_W'(FULL_SCALE);

  logic [CODE_W-1:0] larger;
  logic [SW-1:0]     sat_d, duty_q, duty_d;
  logic              ovt_q, ovt_d;

  always_comb begin
    larger = (temp_code > floor_code) ? temp_code : floor_code;
    sat_d  = (larger >= FS_CODE) ? SW'(FULL_SCALE) : SW'(larger);
    duty_d = wrap ? sat_d : duty_q;
    ovt_d  = (temp_code >= FS_CODE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      ovt_q  <= 1'b0;
    end else begin
      duty_q <= duty_d;
      ovt_q  <= ovt_d;
    end
  end

  assign duty      = duty_q;
  assign over_temp = ovt_q;

  AST_DUTY_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(duty_q)); // R4
  AST_DUTY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    duty_q <= SW'(FULL_SCALE)); // R5
  AST_OVT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code >= FS_CODE) |=> over_temp); // R6
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
  parameter int CODE_W     = 8,
  parameter int FULL_SCALE = 200,
  parameter int PRESC_DIV  = 8333
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] temp_code,
  input  logic [CODE_W-1:0] floor_code,
  input  logic              force_on,
  input  logic              force_off,
  output logic              pwm_out,
  output logic              period_strobe,
  output logic              rise_pulse,
  output logic              over_temp
);
  import fan_pwm_pkg::*;

  localparam int SW = $clog2(FULL_SCALE + 1);

  // Reset: asserted asynchronously, released after two clock edges.
  logic rs_meta_q, rs_core_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_core_q <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_core_q <= rs_meta_q;
    end
  end

  logic          tick, wrap;
  logic [SW-1:0] slot, duty;

  fan_pwm_prescaler #(.PRESC_DIV(PRESC_DIV)) u_presc (
    .clk(clk), .rst_n(rs_core_q), .tick(tick)
  );

  fan_pwm_slot_ctr #(.FULL_SCALE(FULL_SCALE)) u_slot (
    .clk(clk), .rst_n(rs_core_q), .tick(tick), .slot(slot), .wrap(wrap)
  );

  fan_pwm_duty_sel #(.CODE_W(CODE_W), .FULL_SCALE(FULL_SCALE)) u_duty (
    .clk(clk), .rst_n(rs_core_q), .wrap(wrap),
    .temp_code(temp_code), .floor_code(floor_code),
    .duty(duty), .over_temp(over_temp)
  );

  drv_src_t src;
  logic     out_q, out_d, stb_q, rise_q, rise_d;

  always_comb begin
    if (force_off)     src = DRV_LOW;
    else if (force_on) src = DRV_HIGH;
    else               src = DRV_DUTY;
    unique case (src)
      DRV_LOW:  out_d = 1'b0;
      DRV_HIGH: out_d = 1'b1;
      default:  out_d = (slot < duty);
    endcase
    rise_d = out_d && !out_q;
  end

  always_ff @(posedge clk or negedge rs_core_q) begin
    if (!rs_core_q) begin
      out_q  <= 1'b0;
      stb_q  <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      out_q  <= out_d;
      stb_q  <= wrap;
      rise_q <= rise_d;
    end
  end

  assign pwm_out       = out_q;
  assign period_strobe = stb_q;
  assign rise_pulse    = rise_q;

  AST_FORCE_OFF_WINS: assert property (@(posedge clk) disable iff (!rs_core_q)
    force_off |=> !pwm_out); // R7
  AST_FORCE_ON_HIGH: assert property (@(posedge clk) disable iff (!rs_core_q)
    (force_on && !force_off) |=> pwm_out); // R7
  AST_RISE_MARKS_EDGE: assert property (@(posedge clk) disable iff (!rs_core_q)
    (!pwm_out && out_d) |=> rise_pulse); // R8
  AST_RISE_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rs_core_q)
    rise_pulse |-> pwm_out); // R8
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rs_core_q)
    period_strobe |=> !period_strobe); // R2
endmodule

// File: tb/tb_fan_pwm_gen.sv
module tb_fan_pwm_gen;
  localparam int CW = 4;
  localparam int FS = 10;
  localparam int PD = 3;
  localparam int PER = FS * PD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] temp_code = '0, floor_code = '0;
  logic force_on = 1'b0, force_off = 1'b0;
  logic pwm_out, period_strobe, rise_pulse, over_temp;

  int checks = 0, failures = 0, cyc = 0;

  always #2 clk = ~clk;

  fan_pwm_gen #(.CODE_W(CW), .FULL_SCALE(FS), .PRESC_DIV(PD)) dut (
    .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .floor_code(floor_code),
    .force_on(force_on), .force_off(force_off), .pwm_out(pwm_out),
    .period_strobe(period_strobe), .rise_pulse(rise_pulse), .over_temp(over_temp)
  );

  // Behavioural reference model, stepped on each rising edge.
  int m_s1 = 0, m_s2 = 0, m_pre = 0, m_slot = 0, m_duty = 0;
  int m_out = 0, m_stb = 0, m_rise = 0, m_ovt = 0;

  always @(posedge clk) begin
    int big, nout;
    cyc++;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_pre = 0; m_slot = 0; m_duty = 0;
      m_out = 0; m_stb = 0; m_rise = 0; m_ovt = 0;
    end else begin
      if (m_s2 != 0) begin
        big  = (temp_code > floor_code) ? int'(temp_code) : int'(floor_code);
        if (big > FS) big = FS;
        nout = force_off ? 0 : (force_on ? 1 : ((m_slot < m_duty) ? 1 : 0));
        m_rise = (nout == 1 && m_out == 0) ? 1 : 0;
        m_out  = nout;
        m_ovt  = (int'(temp_code) >= FS) ? 1 : 0;
        m_stb  = 0;
        if (m_pre == PD - 1) begin
          m_pre = 0;
          if (m_slot == FS - 1) begin
            m_slot = 0; m_duty = big; m_stb = 1;
          end else m_slot++;
        end else m_pre++;
      end
      m_s2 = m_s1;
      m_s1 = 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && m_s2 != 0) begin
      chk("R3", "pwm_out vs model", int'(pwm_out), m_out);
      chk("R2", "period_strobe vs model", int'(period_strobe), m_stb);
      chk("R8", "rise_pulse vs model", int'(rise_pulse), m_rise);
      chk("R6", "over_temp vs model", int'(over_temp), m_ovt);
    end
  end

  task automatic wait_strobe();
    do @(negedge clk); while (!period_strobe);
  endtask

  task automatic high_count(output int highs, output int rises);
    highs = 0; rises = 0;
    wait_strobe();
    for (int k = 0; k < PER; k++) begin
      @(negedge clk);
      highs += int'(pwm_out);
      rises += int'(rise_pulse);
    end
  endtask

  task automatic set_codes(input int t, input int f);
    @(negedge clk);
    temp_code = CW'(t); floor_code = CW'(f);
  endtask

  int h, r, gap;

  initial begin
    // R1: reset state, including the two-cycle release
    repeat (3) @(negedge clk);
    chk("R1", "pwm_out in reset", int'(pwm_out), 0);
    chk("R1", "strobe in reset", int'(period_strobe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "over_temp after release", int'(over_temp), 0);
    chk("R1", "rise after release", int'(rise_pulse), 0);

    // R3: temperature code sets duty
    set_codes(4, 0);
    high_count(h, r);
    chk("R3", "high cycles temp=4", h, 4 * PD);
    chk("R8", "rises per period", r, 1);

    // R3: floor wins when larger
    set_codes(2, 6);
    high_count(h, r);
    chk("R3", "high cycles floor=6", h, 6 * PD);

    // R2: period length
    wait_strobe();
    gap = 0;
    do begin @(negedge clk); gap++; end while (!period_strobe);
    chk("R2", "strobe spacing", gap, PER);

    // R5: zero codes, never high
    set_codes(0, 0);
    high_count(h, r);
    chk("R5", "high cycles zero code", h, 0);
    chk("R8", "no rise at zero", r, 0);

    // R5/R6: above full scale saturates, flag set
    set_codes(12, 0);
    high_count(h, r);
    chk("R5", "high cycles over full scale", h, PER);
    chk("R6", "over_temp at full demand", int'(over_temp), 1);

    // R6: floor at full scale does not raise flag
    set_codes(0, 15);
    @(negedge clk);
    chk("R6", "over_temp from floor only", int'(over_temp), 0);
    high_count(h, r);
    chk("R5", "high cycles floor full", h, PER);

    // R4: mid-period change has no effect until the boundary
    set_codes(3, 0);
    wait_strobe();
    h = 0;
    for (int k = 0; k < PER; k++) begin
      @(negedge clk);
      if (k == 2) begin temp_code = CW'(8); end
      h += int'(pwm_out);
    end
    chk("R4", "mid-period change ignored", h, 3 * PD);
    high_count(h, r);
    chk("R4", "new duty next period", h, 8 * PD);

    // R7: overrides
    set_codes(0, 0);
    force_on = 1'b1;
    @(negedge clk);
    chk("R7", "force_on drives high", int'(pwm_out), 1);
    high_count(h, r);
    chk("R7", "force_on full period", h, PER);
    force_off = 1'b1;
    @(negedge clk);
    chk("R7", "force_off beats force_on", int'(pwm_out), 0);
    high_count(h, r);
    chk("R7", "force_off full period", h, 0);
    force_off = 1'b0; force_on = 1'b0;

    // R1: reset mid-run
    set_codes(9, 0);
    high_count(h, r);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "pwm_out after reset assert", int'(pwm_out), 0);
    chk("R1", "over_temp after reset assert", int'(over_temp), 0);
    rst_n = 1'b1;
    high_count(h, r);
    chk("R3", "duty after re-reset", h, 9 * PD);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 20000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule